// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the combinational execute stage of a 32-bit load/store processor. Each evaluation takes two register operands, a 16-bit immediate, a 5-bit constant shift amount and the two decode fields of the instruction: the 6-bit primary opcode and the 6-bit function field used by register-to-register operations. It returns a 32-bit result, a signed-overflow flag and a zero flag in the same cycle. There is no internal state, so the outputs follow the inputs.

The block handles several operation groups. It does addition and subtraction in trapping and non-trapping variants, and it does the bitwise logic operations in register and immediate forms. It also does signed and unsigned set-on-less-than, the load of an upper immediate, and left, logical-right and arithmetic-right shifts. A shift takes its amount either from the constant field or from the low bits of a register. Arithmetic immediates are sign-extended and logic immediates are zero-extended. The overflow flag is for trap logic further down the pipeline, and the zero flag is for branch resolution.

Top module: `int_alu_shift`

## Requirements
- R1: With op_code 0, fn_code 32 (add) gives src_a+src_b and fn_code 34 (sub) gives src_a-src_b, both modulo 2^32. op_code 8 gives src_a plus imm16 sign-extended. For these three forms ovf is 1 exactly when the true signed result falls outside the 32-bit two's-complement range.
- R2: With op_code 0, fn_code 33 gives the same sum as add and fn_code 35 gives the same difference as sub. op_code 9 gives the same sum as op_code 8. For all three, ovf is always 0.
- R3: With op_code 0, fn_code 36, 37, 38 and 39 give src_a AND, OR, XOR and NOR src_b.
- R4: op_code 12, 13 and 14 give src_a AND, OR and XOR imm16, with imm16 zero-extended.
- R5: Set-on-less-than gives 1 when the first operand is below the second and 0 otherwise, with bits 31..1 always 0. The four forms are: fn_code 42 (signed compare with src_b) and fn_code 43 (unsigned compare with src_b), both with op_code 0; op_code 10 (signed compare with imm16 sign-extended); and op_code 11 (unsigned compare with imm16 sign-extended).
- R6: op_code 15 places imm16 in bits 31..16 and clears bits 15..0.
- R7: With op_code 0, fn_code 0, 2 and 3 shift src_b by sh_amt. fn_code 0 shifts left and fn_code 2 shifts right, both filling with zeros. fn_code 3 shifts right and copies bit 31 into the vacated bits.
- R8: With op_code 0, fn_code 4, 6 and 7 shift src_b left-logical, right-logical and right-arithmetic by src_a[4:0]. src_a[31:5] has no effect on the result.
- R9: zero is 1 exactly when res equals 0.
- R10: Any op_code not listed above, or op_code 0 with an unlisted fn_code, gives res 0 and ovf 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Primary opcode field |
| fn_code | input | 6 | Function field, used when op_code is 0 |
| src_a | input | 32 | First register operand; shift amount for variable shifts |
| src_b | input | 32 | Second register operand; value shifted by shift operations |
| imm16 | input | 16 | Immediate constant |
| sh_amt | input | 5 | Constant shift amount |
| res | output | 32 | Result |
| ovf | output | 1 | Signed overflow of add, sub and add-immediate |
| zero | output | 1 | Result equals zero |

## Verification
The block has no internal state, so a wrong decode, extension or fill shows on res, ovf or zero in the same cycle as the stimulus that reaches it. A fault stays hidden only if no vector sends the affected code through the affected path. For that reason the bench drives every listed code at the edge operands: the sign boundaries for overflow, shift amounts of 0 and 31, a negative immediate under zero-extended and sign-extended forms, and upper amount bits set in variable shifts. It adds random operands over all codes and over unlisted codes, and compares every cycle against a behavioural model.

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [5:0]            op_code,
  input  logic [5:0]            fn_code,
  input  logic [DW-1:0]         src_a,
  input  logic [DW-1:0]         src_b,
  input  logic [IW-1:0]         imm16,
  input  logic [$clog2(DW)-1:0] sh_amt,
  output logic [DW-1:0]         res,
  output logic                  ovf,
  output logic                  zero
);
  localparam int SW = $clog2(DW);

  logic [DW-1:0] imm_sx, imm_zx, opnd, add_b, sum;
  logic [DW-1:0] shl_out, shr_out;
  logic [SW-1:0] amt;
  logic          do_sub, use_imm, trap_ok, arith_fill, var_amt, sv_ovf;
  logic          lt_s, lt_u;

  assign imm_sx = {{(DW-IW){imm16[IW-1]}}, imm16};
  assign imm_zx = {{(DW-IW){1'b0}}, imm16};

  always_comb begin
    do_sub     = 1'b0;
    use_imm    = (op_code != 6'd0);
    trap_ok    = 1'b0;
    arith_fill = 1'b0;
    var_amt    = 1'b0;
    if (op_code == 6'd0) begin
      do_sub     = (fn_code == 6'd34) || (fn_code == 6'd35) ||
                   (fn_code == 6'd42) || (fn_code == 6'd43);
      trap_ok    = (fn_code == 6'd32) || (fn_code == 6'd34);
      arith_fill = (fn_code == 6'd3) || (fn_code == 6'd7);
      var_amt    = fn_code[2];
    end else begin
      do_sub  = (op_code == 6'd10) || (op_code == 6'd11);
      trap_ok = (op_code == 6'd8);
    end
  end

  assign opnd  = use_imm ? imm_sx : src_b;
  assign add_b = do_sub ? ~opnd : opnd;
  assign sum   = src_a + add_b + {{(DW-1){1'b0}}, do_sub};
  assign sv_ovf = (src_a[DW-1] == add_b[DW-1]) && (sum[DW-1] != src_a[DW-1]);

  assign lt_s = sum[DW-1] ^ sv_ovf;
  assign lt_u = src_a < opnd;

  assign amt = var_amt ? src_a[SW-1:0] : sh_amt;

  always_comb begin
    shl_out = src_b;
    shr_out = src_b;
    for (int s = 0; s < SW; s++) begin
      if (amt[s]) begin
        shl_out = shl_out << (1 << s);
        shr_out = arith_fill ? DW'($signed(shr_out) >>> (1 << s)) : (shr_out >> (1 << s));
      end
    end
  end

  always_comb begin
    res = '0;
    ovf = 1'b0;
    if (op_code == 6'd0) begin
      case (fn_code)
        6'd32, 6'd33, 6'd34, 6'd35: res = sum;
        6'd36: res = src_a & src_b;
        6'd37: res = src_a | src_b;
        6'd38: res = src_a ^ src_b;
        6'd39: res = ~(src_a | src_b);
        6'd42: res = {{(DW-1){1'b0}}, lt_s};
        6'd43: res = {{(DW-1){1'b0}}, lt_u};
        6'd0, 6'd4: res = shl_out;
        6'd2, 6'd3, 6'd6, 6'd7: res = shr_out;
        default: res = '0;
      endcase
    end else begin
      case (op_code)
        6'd8, 6'd9: res = sum;
        6'd10: res = {{(DW-1){1'b0}}, lt_s};
        6'd11: res = {{(DW-1){1'b0}}, lt_u};
        6'd12: res = src_a & imm_zx;
        6'd13: res = src_a | imm_zx;
        6'd14: res = src_a ^ imm_zx;
        6'd15: res = {imm16, {(DW-IW){1'b0}}};
        default: res = '0;
      endcase
    end
    ovf = trap_ok & sv_ovf;
  end

  assign zero = ~|res;
endmodule

module int_alu_shift_chk #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input logic [5:0]    op_code,
  input logic [5:0]    fn_code,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_b,
  input logic [IW-1:0] imm16,
  input logic [DW-1:0] res,
  input logic          ovf,
  input logic          zero
);
  logic is_r;
  assign is_r = (op_code == 6'd0);

  always_comb begin
    if (!$isunknown({op_code, fn_code, src_a, src_b, imm16, res, ovf, zero})) begin
      if ((is_r && (fn_code == 6'd33 || fn_code == 6'd35)) || op_code == 6'd9)
        a_r2_no_overflow: assert (!ovf) else $error("unsigned form raised ovf");
      if (ovf)
        a_r1_ovf_sign: assert (res[DW-1] != src_a[DW-1]) else $error("ovf without sign flip");
      if (op_code == 6'd15)
        a_r6_lui_place: assert (res == {imm16, {(DW-IW){1'b0}}}) else $error("lui placement");
      if ((is_r && (fn_code == 6'd42 || fn_code == 6'd43)) || op_code == 6'd10 || op_code == 6'd11)
        a_r5_bool_result: assert (res[DW-1:1] == '0) else $error("slt upper bits");
      if (op_code == 6'd12)
        a_r4_zext_and: assert (res[DW-1:IW] == '0) else $error("andi upper bits");
      a_r9_zero_flag: assert (zero == (res == '0)) else $error("zero flag");
      if (is_r && fn_code == 6'd39)
        a_r3_nor_disjoint: assert ((res & (src_a | src_b)) == '0) else $error("nor overlap");
    end
  end
endmodule

bind int_alu_shift int_alu_shift_chk #(.DW(DW), .IW(IW)) chk_i (
  .op_code(op_code), .fn_code(fn_code), .src_a(src_a), .src_b(src_b),
  .imm16(imm16), .res(res), .ovf(ovf), .zero(zero)
);

// File: tb/int_alu_shift_tb.sv
module int_alu_shift_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  op_code = '0, fn_code = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  sh_amt = '0;
  logic [31:0] res;
  logic        ovf, zero;
  int n_cmp = 0, n_bad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  int_alu_shift dut_i (.op_code(op_code), .fn_code(fn_code), .src_a(src_a), .src_b(src_b),
                       .imm16(imm16), .sh_amt(sh_amt), .res(res), .ovf(ovf), .zero(zero));

  task automatic model(output logic [31:0] r, output logic v, output string tag);
    longint sa, sb, t;
    logic [31:0] sx;
    sa = longint'($signed(src_a));
    sb = longint'($signed(src_b));
    sx = {{16{imm16[15]}}, imm16};
    r = 32'd0; v = 1'b0; tag = "R10";
    if (op_code == 0) begin
      case (fn_code)
        32: begin t = sa + sb; r = src_a + src_b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); tag = "R1"; end
        34: begin t = sa - sb; r = src_a - src_b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); tag = "R1"; end
        33: begin r = src_a + src_b; tag = "R2"; end
        35: begin r = src_a - src_b; tag = "R2"; end
        36: begin r = src_a & src_b; tag = "R3"; end
        37: begin r = src_a | src_b; tag = "R3"; end
        38: begin r = src_a ^ src_b; tag = "R3"; end
        39: begin r = ~(src_a | src_b); tag = "R3"; end
        42: begin r = (sa < sb) ? 1 : 0; tag = "R5"; end
        43: begin r = (src_a < src_b) ? 1 : 0; tag = "R5"; end
        0:  begin r = src_b << sh_amt; tag = "R7"; end
        2:  begin r = src_b >> sh_amt; tag = "R7"; end
        3:  begin r = 32'($signed(src_b) >>> sh_amt); tag = "R7"; end
        4:  begin r = src_b << src_a[4:0]; tag = "R8"; end
        6:  begin r = src_b >> src_a[4:0]; tag = "R8"; end
        7:  begin r = 32'($signed(src_b) >>> src_a[4:0]); tag = "R8"; end
        default: ;
      endcase
    end else begin
      case (op_code)
        8:  begin t = sa + longint'($signed(sx)); r = src_a + sx; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); tag = "R1"; end
        9:  begin r = src_a + sx; tag = "R2"; end
        10: begin r = (sa < longint'($signed(sx))) ? 1 : 0; tag = "R5"; end
        11: begin r = (src_a < sx) ? 1 : 0; tag = "R5"; end
        12: begin r = src_a & {16'd0, imm16}; tag = "R4"; end
        13: begin r = src_a | {16'd0, imm16}; tag = "R4"; end
        14: begin r = src_a ^ {16'd0, imm16}; tag = "R4"; end
        15: begin r = {imm16, 16'd0}; tag = "R6"; end
        default: ;
      endcase
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [4:0] sh);
    logic [31:0] er; logic ev; string tg;
    @(posedge clk); #1;
    op_code = op; fn_code = fn; src_a = a; src_b = b; imm16 = im; sh_amt = sh;
    model(er, ev, tg);
    @(negedge clk);
    n_cmp++;
    if (res !== er || ovf !== ev) begin
      n_bad++;
      $display("FAIL %s op=%0d fn=%0d res=%h ovf=%b expected res=%h ovf=%b", tg, op, fn, res, ovf, er, ev);
    end
    n_cmp++;
    if (zero !== (er == 32'd0)) begin
      n_bad++;
      $display("FAIL R9 op=%0d fn=%0d zero=%b expected %b", op, fn, zero, er == 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired res=%h expected completion", res);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] rops [22];
    logic [5:0] iops [8];
    rops = '{6'd32,6'd33,6'd34,6'd35,6'd36,6'd37,6'd38,6'd39,6'd42,6'd43,6'd0,6'd2,6'd3,6'd4,6'd6,6'd7,
             6'd1,6'd5,6'd8,6'd40,6'd44,6'd63};
    iops = '{6'd8,6'd9,6'd10,6'd11,6'd12,6'd13,6'd14,6'd15};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs decode as a zero shift of zero (R7, R9)
    @(negedge clk);
    n_cmp++;
    if (res !== 32'd0 || ovf !== 1'b0 || zero !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 idle res=%h ovf=%b zero=%b expected 0/0/1", res, ovf, zero);
    end
    // R1 overflow boundaries
    apply(0, 32, 32'h7FFF_FFFF, 32'h1, 0, 0);
    apply(0, 32, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0);
    apply(0, 32, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    apply(0, 34, 32'h8000_0000, 32'h1, 0, 0);
    apply(0, 34, 32'h0, 32'h8000_0000, 0, 0);
    apply(0, 34, 32'h5, 32'h5, 0, 0);
    apply(8, 0, 32'h7FFF_FFFF, 0, 16'h0001, 0);
    apply(8, 0, 32'h8000_0000, 0, 16'hFFFF, 0);
    apply(8, 0, 32'h10, 0, 16'hFFF0, 0);
    // R2 no overflow
    apply(0, 33, 32'h7FFF_FFFF, 32'h1, 0, 0);
    apply(0, 35, 32'h8000_0000, 32'h1, 0, 0);
    apply(9, 0, 32'h7FFF_FFFF, 0, 16'h0001, 0);
    // R3, R4 logic
    apply(0, 39, 32'h0, 32'h0, 0, 0);
    apply(0, 39, 32'hF0F0_0000, 32'h0000_0F0F, 0, 0);
    apply(12, 0, 32'hFFFF_FFFF, 0, 16'h8001, 0);
    apply(13, 0, 32'h0, 0, 16'hFFFF, 0);
    apply(14, 0, 32'hFFFF_FFFF, 0, 16'h8000, 0);
    // R5 compares
    apply(0, 42, 32'hFFFF_FFFF, 32'h1, 0, 0);
    apply(0, 43, 32'hFFFF_FFFF, 32'h1, 0, 0);
    apply(0, 42, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0);
    apply(10, 0, 32'hFFFF_FFFE, 0, 16'hFFFF, 0);
    apply(11, 0, 32'hFFFF_FFFE, 0, 16'hFFFF, 0);
    apply(11, 0, 32'hFFFF_FFFF, 0, 16'hFFFF, 0);
    // R6
    apply(15, 0, 32'hDEAD_BEEF, 32'h1234_5678, 16'hA5C3, 5'd9);
    // R7 constant shifts
    apply(0, 0, 32'h0, 32'h8000_0001, 0, 5'd31);
    apply(0, 2, 32'h0, 32'h8000_0001, 0, 5'd31);
    apply(0, 3, 32'h0, 32'h8000_0000, 0, 5'd31);
    apply(0, 3, 32'h0, 32'h8000_0000, 0, 5'd0);
    apply(0, 3, 32'h0, 32'h4000_0000, 0, 5'd4);
    // R8 variable shifts with upper amount bits set
    apply(0, 4, 32'hFFFF_FFE4, 32'h0000_0003, 0, 5'd0);
    apply(0, 6, 32'hFFFF_FFE4, 32'hF000_0000, 0, 5'd17);
    apply(0, 7, 32'h0000_0FFF, 32'h8000_0000, 0, 5'd1);
    // R10 unlisted codes
    apply(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd3);
    apply(6'd63, 0, 32'h7FFF_FFFF, 32'h1, 16'hFFFF, 0);
    apply(6'd35, 0, 32'h1234, 32'h5678, 16'h9ABC, 0);
    // random sweep over all listed and some unlisted codes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) ra = {ra[31], {31{ra[30]}}};
      if ($urandom_range(0, 2) == 0)
        apply(iops[$urandom_range(0, 7)], 6'($urandom), ra, rb, 16'($urandom), 5'($urandom));
      else if ($urandom_range(0, 9) == 0)
        apply(6'($urandom_range(16, 63)), 6'($urandom), ra, rb, 16'($urandom), 5'($urandom));
      else
        apply(0, rops[$urandom_range(0, 21)], ra, rb, 16'($urandom), 5'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule